// File: doc/BRIEF.md
# Legacy Display Register Port Bank

This block is the byte-wide host register front end of a display controller that keeps the classic PC graphics register layout. The host reaches it over a simple synchronous strobe bus. Each access carries an 8-bit offset, which is the classic port number less 0x300. The block holds the register groups that set up the display: a miscellaneous output byte, a sequencer group, a CRT controller group, a graphics controller group and an attribute group. All of their contents are driven out as flat vectors to the downstream timing and pixel logic.

The sequencer, CRT controller and graphics controller groups each use a pair of ports. The host first writes a register number to an index port, then reads or writes that register through a data port. The attribute group has a single write port. Successive writes to that port alternate between selecting a register and writing it. The host puts the port back in the select state by reading input status 1. That status byte reports vertical retrace and display-disable flags, which come in from the timing generator. The first eight CRT controller registers can be locked against writes by a bit held in CRT controller register 0x11.

Top module: `vga_port_bank`

## Requirements
- R1: After synchronous reset, every index is 0x00, every register byte is 0x00 except CRT controller register 0x11, which is 0x80, the attribute port is in the select state, and `io_rdata` is 0x00.
- R2: A write at offset 0xC2 loads the miscellaneous output byte. It reads back at offset 0xCC and appears on `misc_out` one cycle after the write.
- R3: The index/data port pairs are sequencer 0xC4/0xC5, CRT controller 0xD4/0xD5 and graphics controller 0xCE/0xCF. A write to an index port stores the whole byte, and a read of that port returns it. A data port write goes to the selected register, and a data port read returns that register. Register k of a group is driven on bits [8k+7:8k] of the group's output vector.
- R4: When the stored index is at or above a group's register count, a data read returns 0x00 and a data write changes no register.
- R5: While bit 7 of CRT controller register 0x11 is 1, data writes to CRT controller registers 0 through 7 are discarded. Registers 8 and above, including 0x11 itself, stay writable.
- R6: Offset 0xC0 is the attribute port. After reset or a status read, the first write there stores the attribute index and the next write stores data into the selected attribute register. The two roles keep alternating on every further write. A read of 0xC0 returns the attribute index, and a read of 0xC1 returns the selected attribute register (0x00 when out of range). Reads at 0xC0 and 0xC1 do not change the alternation.
- R7: A read at offset 0xDA returns bit 3 = `vretrace_in` and bit 0 = `disp_off_in`, sampled in the strobe cycle, with all other bits 0. The same read returns the attribute port to the select state.
- R8: `io_rdata` is registered. It takes the addressed value on the clock edge that ends a read strobe cycle and holds it until the next read. Offsets not listed here, and the write-only 0xC2, read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Port offset (classic port number minus 0x300) |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| vretrace_in | input | 1 | Vertical retrace flag from the timing generator |
| disp_off_in | input | 1 | Display-disable flag from the timing generator |
| misc_out | output | 8 | Miscellaneous output byte |
| seq_out | output | 8*SEQ_N | Sequencer registers, register k at byte k |
| crtc_out | output | 8*CRTC_N | CRT controller registers, register k at byte k |
| gc_out | output | 8*GC_N | Graphics controller registers, register k at byte k |
| attr_out | output | 8*ATTR_N | Attribute registers, register k at byte k |

## Verification
The bench builds the block with its default group sizes: 5 sequencer, 25 CRT controller, 9 graphics controller and 21 attribute registers. With these sizes every register of every group can be written and read back through its ports. The sizes also place the CRT lock register at 0x11 inside the group, so the lock can be set, cleared and set again around full sweeps of registers 0 to 7. Indices just past each group's count, and 0xFF, cover the out-of-range path. All four combinations of the two status flags are read back, along with the attribute port's alternation before and after a resynchronising status read.

// File: rtl/vga_port_pkg.sv
package vga_port_pkg;

    typedef logic [7:0] byte_t;

    // Port offsets (classic port number minus 0x300)
    localparam byte_t OFS_ATTR_PORT = 8'hC0;
    localparam byte_t OFS_ATTR_RD   = 8'hC1;
    localparam byte_t OFS_MISC_W    = 8'hC2;
    localparam byte_t OFS_SEQ_I     = 8'hC4;
    localparam byte_t OFS_SEQ_D     = 8'hC5;
    localparam byte_t OFS_MISC_R    = 8'hCC;
    localparam byte_t OFS_GC_I      = 8'hCE;
    localparam byte_t OFS_GC_D      = 8'hCF;
    localparam byte_t OFS_CRT_I     = 8'hD4;
    localparam byte_t OFS_CRT_D     = 8'hD5;
    localparam byte_t OFS_STAT      = 8'hDA;

    // CRT controller write lock
    localparam int CRT_LOCK_REG  = 17;
    localparam int CRT_LOCK_BIT  = 7;
    localparam int CRT_LOCK_SPAN = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ATTR_PORT,
        SEL_ATTR_RD,
        SEL_MISC_W,
        SEL_MISC_R,
        SEL_SEQ_I,
        SEL_SEQ_D,
        SEL_GC_I,
        SEL_GC_D,
        SEL_CRT_I,
        SEL_CRT_D,
        SEL_STAT
    } port_sel_e;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
    } bank_wr_t;

    function automatic port_sel_e decode_port(byte_t a);
        case (a)
            OFS_ATTR_PORT: return SEL_ATTR_PORT;
            OFS_ATTR_RD:   return SEL_ATTR_RD;
            OFS_MISC_W:    return SEL_MISC_W;
            OFS_MISC_R:    return SEL_MISC_R;
            OFS_SEQ_I:     return SEL_SEQ_I;
            OFS_SEQ_D:     return SEL_SEQ_D;
            OFS_GC_I:      return SEL_GC_I;
            OFS_GC_D:      return SEL_GC_D;
            OFS_CRT_I:     return SEL_CRT_I;
            OFS_CRT_D:     return SEL_CRT_D;
            OFS_STAT:      return SEL_STAT;
            default:       return SEL_NONE;
        endcase
    endfunction

    function automatic byte_t status_byte(logic retrace, logic disp_off);
        return {4'b0000, retrace, 2'b00, disp_off};
    endfunction

    function automatic bank_wr_t pair_strobes(logic wr, port_sel_e sel,
                                              port_sel_e isel, port_sel_e dsel);
        bank_wr_t s;
        s.idx_wr = wr && (sel == isel);
        s.dat_wr = wr && (sel == dsel);
        return s;
    endfunction

endpackage

// File: rtl/vga_idx_bank.sv
module vga_idx_bank
    import vga_port_pkg::*;
#(
    parameter int N = 8,
    parameter int LOCK_N = 0,
    parameter logic [N*8-1:0] INIT = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  bank_wr_t       wr,
    input  byte_t          wdata,
    input  logic           lock,
    output byte_t          idx,
    output byte_t          dat,
    output logic [N*8-1:0] flat
);
    localparam int    IW   = (N > 1) ? $clog2(N) : 1;
    localparam byte_t LAST = byte_t'(N - 1);

    byte_t mem [N];
    logic  in_range;
    logic  guarded;

    assign in_range = (idx <= LAST);

    generate
        if (LOCK_N > 0) begin : g_lock
            assign guarded = lock && (idx < byte_t'(LOCK_N));
        end else begin : g_nolock
            assign guarded = lock && 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            for (int i = 0; i < N; i++) mem[i] <= INIT[i*8 +: 8];
        end else if (wr.idx_wr) begin
            idx <= wdata;
        end else if (wr.dat_wr && in_range && !guarded) begin
            mem[idx[IW-1:0]] <= wdata;
        end
    end

    assign dat = in_range ? mem[idx[IW-1:0]] : 8'h00;

    generate
        for (genvar g = 0; g < N; g++) begin : g_flat
            assign flat[g*8 +: 8] = mem[g];
        end
    endgenerate

    // R5
    lock_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.dat_wr && !wr.idx_wr && guarded) |=> $stable(flat));

    // R4
    range_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.dat_wr && !wr.idx_wr && !in_range) |=> $stable(flat));

    // R3
    data_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.dat_wr && !wr.idx_wr && in_range && !guarded) |=> (dat == $past(wdata)));

    // R3
    index_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr.idx_wr |=> (idx == $past(wdata)));

endmodule

// File: rtl/vga_attr_flip.sv
module vga_attr_flip (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    output logic at_data
);
    always_ff @(posedge clk) begin
        if (rst || clear) at_data <= 1'b0;
        else if (step)    at_data <= ~at_data;
    end

    // R7
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !at_data);

    // R6
    alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (at_data != $past(at_data)));

endmodule

// File: rtl/vga_port_bank.sv
module vga_port_bank
    import vga_port_pkg::*;
#(
    parameter int SEQ_N  = 5,
    parameter int CRTC_N = 25,
    parameter int GC_N   = 9,
    parameter int ATTR_N = 21
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic                vretrace_in,
    input  logic                disp_off_in,
    output logic [7:0]          misc_out,
    output logic [SEQ_N*8-1:0]  seq_out,
    output logic [CRTC_N*8-1:0] crtc_out,
    output logic [GC_N*8-1:0]   gc_out,
    output logic [ATTR_N*8-1:0] attr_out
);
    localparam int LOCK_POS = CRT_LOCK_REG * 8 + CRT_LOCK_BIT;
    localparam logic [CRTC_N*8-1:0] CRTC_INIT =
        {{(CRTC_N*8-1){1'b0}}, 1'b1} << LOCK_POS;

    port_sel_e sel;
    bank_wr_t  seq_wr, crt_wr, gc_wr, attr_wr;
    logic      attr_at_data, attr_hit, stat_rd;
    byte_t     seq_idx, seq_dat, crt_idx, crt_dat, gc_idx, gc_dat, attr_idx, attr_dat;
    byte_t     rd_mux;

    assign sel      = decode_port(io_addr);
    assign seq_wr   = pair_strobes(io_wr, sel, SEL_SEQ_I, SEL_SEQ_D);
    assign crt_wr   = pair_strobes(io_wr, sel, SEL_CRT_I, SEL_CRT_D);
    assign gc_wr    = pair_strobes(io_wr, sel, SEL_GC_I, SEL_GC_D);
    assign attr_hit = io_wr && (sel == SEL_ATTR_PORT);
    assign attr_wr.idx_wr = attr_hit && !attr_at_data;
    assign attr_wr.dat_wr = attr_hit && attr_at_data;
    assign stat_rd  = io_rd && (sel == SEL_STAT);

    vga_idx_bank #(.N(SEQ_N)) u_seq (
        .clk(clk), .rst(rst), .wr(seq_wr), .wdata(io_wdata), .lock(1'b0),
        .idx(seq_idx), .dat(seq_dat), .flat(seq_out));

    vga_idx_bank #(.N(CRTC_N), .LOCK_N(CRT_LOCK_SPAN), .INIT(CRTC_INIT)) u_crt (
        .clk(clk), .rst(rst), .wr(crt_wr), .wdata(io_wdata),
        .lock(crtc_out[LOCK_POS]),
        .idx(crt_idx), .dat(crt_dat), .flat(crtc_out));

    vga_idx_bank #(.N(GC_N)) u_gc (
        .clk(clk), .rst(rst), .wr(gc_wr), .wdata(io_wdata), .lock(1'b0),
        .idx(gc_idx), .dat(gc_dat), .flat(gc_out));

    vga_idx_bank #(.N(ATTR_N)) u_attr (
        .clk(clk), .rst(rst), .wr(attr_wr), .wdata(io_wdata), .lock(1'b0),
        .idx(attr_idx), .dat(attr_dat), .flat(attr_out));

    vga_attr_flip u_flip (
        .clk(clk), .rst(rst), .step(attr_hit), .clear(stat_rd), .at_data(attr_at_data));

    always_ff @(posedge clk) begin
        if (rst)                                  misc_out <= '0;
        else if (io_wr && sel == SEL_MISC_W)      misc_out <= io_wdata;
    end

    always_comb begin
        case (sel)
            SEL_ATTR_PORT: rd_mux = attr_idx;
            SEL_ATTR_RD:   rd_mux = attr_dat;
            SEL_MISC_R:    rd_mux = misc_out;
            SEL_SEQ_I:     rd_mux = seq_idx;
            SEL_SEQ_D:     rd_mux = seq_dat;
            SEL_GC_I:      rd_mux = gc_idx;
            SEL_GC_D:      rd_mux = gc_dat;
            SEL_CRT_I:     rd_mux = crt_idx;
            SEL_CRT_D:     rd_mux = crt_dat;
            SEL_STAT:      rd_mux = status_byte(vretrace_in, disp_off_in);
            default:       rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        io_rdata <= '0;
        else if (io_rd) io_rdata <= rd_mux;
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

    // R7
    status_value_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (io_rdata == {4'b0000, $past(vretrace_in), 2'b00, $past(disp_off_in)}));

    // R2
    misc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && sel == SEL_MISC_W) |=> (misc_out == $past(io_wdata)));

endmodule

// File: tb/vga_port_bank_test.sv
module vga_port_bank_test;
    localparam int SN = 5;
    localparam int CN = 25;
    localparam int GN = 9;
    localparam int AN = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] io_addr = '0;
    logic io_rd = 1'b0;
    logic io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic vretrace_in = 1'b0;
    logic disp_off_in = 1'b0;
    logic [7:0] misc_out;
    logic [SN*8-1:0] seq_out;
    logic [CN*8-1:0] crtc_out;
    logic [GN*8-1:0] gc_out;
    logic [AN*8-1:0] attr_out;

    int checks = 0;
    int fails = 0;
    logic [7:0] v;
    logic [7:0] crt_exp [CN];

    always #5 clk = ~clk;

    vga_port_bank #(.SEQ_N(SN), .CRTC_N(CN), .GC_N(GN), .ATTR_N(AN)) uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .vretrace_in(vretrace_in),
        .disp_off_in(disp_off_in), .misc_out(misc_out), .seq_out(seq_out),
        .crtc_out(crtc_out), .gc_out(gc_out), .attr_out(attr_out));

    function automatic logic [7:0] pat(int i, int salt);
        return 8'((i * 29 + salt) & 255);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [SN*8-1:0] seq_snap;
        logic [AN*8-1:0] attr_snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata", io_rdata, 8'h00);
        check("R1 misc", misc_out, 8'h00);
        check("R1 seq", 8'(seq_out != '0), 8'h00);
        check("R1 gc", 8'(gc_out != '0), 8'h00);
        check("R1 attr", 8'(attr_out != '0), 8'h00);
        for (int i = 0; i < CN; i++) begin
            crt_exp[i] = (i == 17) ? 8'h80 : 8'h00;
            check("R1 crtc byte", crtc_out[i*8 +: 8], crt_exp[i]);
        end
        rd(8'hD4, v); check("R1 crtc index", v, 8'h00);
        rd(8'hC0, v); check("R1 attr index", v, 8'h00);

        // R2 misc
        wr(8'hC2, 8'hA5);
        check("R2 misc_out", misc_out, 8'hA5);
        rd(8'hCC, v); check("R2 misc read", v, 8'hA5);
        wr(8'hC2, 8'h3C);
        rd(8'hCC, v); check("R2 misc read2", v, 8'h3C);

        // R8 unmapped and write-only offsets, hold
        rd(8'hC2, v); check("R8 write-only", v, 8'h00);
        rd(8'h00, v); check("R8 unmapped", v, 8'h00);
        rd(8'hCC, v);
        repeat (4) @(negedge clk);
        check("R8 hold", io_rdata, 8'h3C);

        // R3 sequencer and graphics sweeps
        for (int i = 0; i < SN; i++) begin
            wr(8'hC4, 8'(i)); rd(8'hC4, v); check("R3 seq index", v, 8'(i));
            wr(8'hC5, pat(i, 3)); rd(8'hC5, v); check("R3 seq data", v, pat(i, 3));
        end
        for (int i = 0; i < SN; i++) check("R3 seq export", seq_out[i*8 +: 8], pat(i, 3));
        for (int i = 0; i < GN; i++) begin
            wr(8'hCE, 8'(i)); rd(8'hCE, v); check("R3 gc index", v, 8'(i));
            wr(8'hCF, pat(i, 71)); rd(8'hCF, v); check("R3 gc data", v, pat(i, 71));
        end
        for (int i = 0; i < GN; i++) check("R3 gc export", gc_out[i*8 +: 8], pat(i, 71));

        // R4 out-of-range indices
        seq_snap = seq_out;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] bad;
            bad = (k == 3) ? 8'hFF : 8'(SN + k);
            wr(8'hC4, bad); wr(8'hC5, 8'h77);
            rd(8'hC5, v); check("R4 seq data", v, 8'h00);
            rd(8'hC4, v); check("R4 seq index", v, bad);
            check("R4 seq unchanged", 8'(seq_out != seq_snap), 8'h00);
        end
        wr(8'hCE, 8'(GN)); wr(8'hCF, 8'h66);
        rd(8'hCF, v); check("R4 gc data", v, 8'h00);
        for (int i = 0; i < GN; i++) check("R4 gc unchanged", gc_out[i*8 +: 8], pat(i, 71));

        // R5 CRT lock
        for (int i = 0; i < 8; i++) begin
            wr(8'hD4, 8'(i)); wr(8'hD5, 8'h5A);
            rd(8'hD5, v); check("R5 locked", v, 8'h00);
        end
        for (int i = 8; i < CN; i++) begin
            if (i != 17) begin
                crt_exp[i] = pat(i, 11);
                wr(8'hD4, 8'(i)); wr(8'hD5, crt_exp[i]);
                rd(8'hD5, v); check("R5 upper writable", v, crt_exp[i]);
            end
        end
        wr(8'hD4, 8'h11); wr(8'hD5, 8'h00); crt_exp[17] = 8'h00;
        rd(8'hD5, v); check("R5 lock reg write", v, 8'h00);
        for (int i = 0; i < 8; i++) begin
            crt_exp[i] = pat(i, 200);
            wr(8'hD4, 8'(i)); wr(8'hD5, crt_exp[i]);
            rd(8'hD5, v); check("R5 unlocked", v, crt_exp[i]);
        end
        wr(8'hD4, 8'h11); wr(8'hD5, 8'h80); crt_exp[17] = 8'h80;
        for (int i = 0; i < 8; i++) begin
            wr(8'hD4, 8'(i)); wr(8'hD5, 8'hEE);
            rd(8'hD5, v); check("R5 relocked", v, crt_exp[i]);
        end
        for (int i = 0; i < CN; i++) check("R5 crtc export", crtc_out[i*8 +: 8], crt_exp[i]);

        // R6 attribute sweep
        rd(8'hDA, v);
        for (int i = 0; i < AN; i++) begin
            wr(8'hC0, 8'(i)); wr(8'hC0, pat(i, 90));
            rd(8'hC0, v); check("R6 attr index", v, 8'(i));
            rd(8'hC1, v); check("R6 attr data", v, pat(i, 90));
        end
        for (int i = 0; i < AN; i++) check("R6 attr export", attr_out[i*8 +: 8], pat(i, 90));
        attr_snap = attr_out;
        wr(8'hC0, 8'h1F); wr(8'hC0, 8'h11);
        rd(8'hC1, v); check("R6 attr out of range", v, 8'h00);
        check("R6 attr unchanged", 8'(attr_out != attr_snap), 8'h00);

        // R7 status bits
        for (int s = 0; s < 4; s++) begin
            vretrace_in = s[1]; disp_off_in = s[0];
            rd(8'hDA, v); check("R7 status", v, {4'b0, s[1], 2'b00, s[0]});
        end
        vretrace_in = 1'b0; disp_off_in = 1'b0;

        // R7 resynchronisation: an index write, then a status read
        wr(8'hC0, 8'h03);
        rd(8'hDA, v);
        wr(8'hC0, 8'h07); wr(8'hC0, 8'h99);
        rd(8'hC0, v); check("R7 resync index", v, 8'h07);
        rd(8'hC1, v); check("R7 resync data", v, 8'h99);
        check("R7 reg3 untouched", attr_out[3*8 +: 8], pat(3, 90));

        // R6 alternation without resync continues across reads
        wr(8'hC0, 8'h04); rd(8'hC0, v); wr(8'hC0, 8'h42);
        check("R6 read keeps phase", attr_out[4*8 +: 8], 8'h42);

        finish_run();
    end
endmodule